// File: doc/BRIEF.md
# SPI Serial Receive Path with Fill and End Interrupts

This block is the receive half of an SPI controller. It takes the serial clock and serial data from the controller's transmit-side timing, puts the incoming bits together into bytes, and hands each byte to software through a single read port. Software reads one byte per strobe.

A mode input chooses between two ways of working. In unit mode, each finished byte goes straight into the output data register, and the FIFO is not used. In sequential mode, finished bytes are stored in a 32-entry FIFO. Software then drains the FIFO in groups of 16.

The block produces two interrupt pulses, a fill interrupt and an end interrupt. In unit mode, both fire together for every byte. In sequential mode, the fill interrupt fires when the FIFO occupancy climbs to the half mark and again when it climbs to the full mark. The end interrupt fires only when the FIFO becomes full.

Top module: `spi_rx_path`

## Requirements
- R1: `sdata_in` is sampled on the first `clk` edge after `sclk_in` rises. Eight samples form one byte, with the first sample as bit 7 and the last sample as bit 0.
- R2: In unit mode (`seq_mode`=0), a finished byte is placed on `rd_data`. In the same cycle, `irq_fill` and `irq_end` pulse together. `fifo_level` stays 0.
- R3: In sequential mode (`seq_mode`=1), finished bytes are stored in a 32-entry FIFO and read out in arrival order. `rd_data` shows the popped byte in the cycle after the `rd_stb` edge, and `fifo_level` drops by one.
- R4: In sequential mode, `irq_fill` pulses once when `fifo_level` climbs from 15 to 16, and once when it climbs from 31 to 32. A fall to 16 caused by reads raises no pulse.
- R5: In sequential mode, `irq_end` pulses only when `fifo_level` climbs to 32, in the same cycle as the matching `irq_fill` pulse.
- R6: A byte that finishes while the FIFO holds 32 entries is dropped, and `fifo_level` stays 32. `overrun` is set to 1 and stays 1 until reset.
- R7: A read strobe while the FIFO is empty leaves `rd_data` unchanged and `fifo_level` at 0.
- R8: When a byte is stored in the same cycle as a read pops one, `fifo_level` is unchanged and the popped byte appears on `rd_data`.
- R9: Each interrupt output is high for exactly one cycle per event.
- R10: After a synchronous reset, `rd_data`, `fifo_level`, `irq_fill`, `irq_end` and `overrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_in | input | 1 | Serial clock, synchronous to `clk`, high and low for at least one `clk` cycle each |
| sdata_in | input | 1 | Serial data, changed by the sender while `sclk_in` is low |
| rd_stb | input | 1 | Read strobe; pops one byte in sequential mode |
| seq_mode | input | 1 | 0 = unit mode, 1 = sequential mode |
| rd_data | output | 8 | Received byte (unit mode) or popped byte (sequential mode) |
| fifo_level | output | 6 | Number of bytes held in the FIFO |
| irq_fill | output | 1 | Fill interrupt pulse |
| irq_end | output | 1 | End interrupt pulse |
| overrun | output | 1 | Sticky flag: a byte was lost because the FIFO was full |

## Verification
A finished byte being stored and a read strobe popping a byte can land on the same clock edge. When that happens, the occupancy count and the output register must both settle correctly.

The bench provokes this case by raising `rd_stb` exactly one cycle after the last serial sampling edge, while the FIFO is half full. It then checks two things. First, `fifo_level` must not move. Second, `rd_data` must be the next byte in arrival order. The newly stored byte is checked later, when it comes out last while the FIFO is drained.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic {MODE_UNIT = 1'b0, MODE_SEQ = 1'b1} rx_mode_e;
endpackage

// File: rtl/spi_rx_deser.sv
module spi_rx_deser #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk,
  input  logic         sdi,
  output logic         byte_vld,
  output logic [W-1:0] byte_q
);
  localparam int unsigned CW = $clog2(W);

  logic         sclk_q;
  logic [W-2:0] sh;
  logic [CW-1:0] cnt;
  logic         rise;

  assign rise = sclk & ~sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      sh       <= '0;
      cnt      <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
    end else begin
      sclk_q   <= sclk;
      byte_vld <= 1'b0;
      if (rise) begin
        sh <= {sh[W-3:0], sdi};
        if (cnt == CW'(W-1)) begin
          cnt      <= '0;
          byte_vld <= 1'b1;
          byte_q   <= {sh, sdi};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R1
  byte_gap_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> !byte_vld);
endmodule

// File: rtl/spi_rx_store.sv
module spi_rx_store
  import spi_rx_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  rx_mode_e      mode,
  input  logic          wr_vld,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_stb,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          ovr
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          is_seq, full, empty, push, pop;

  assign is_seq = (mode == MODE_SEQ);
  assign full   = (level == LW'(DEPTH));
  assign empty  = (level == '0);
  assign push   = is_seq & wr_vld & ~full;
  assign pop    = is_seq & rd_stb & ~empty;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
      ovr   <= 1'b0;
      dout  <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (is_seq && wr_vld && full) ovr <= 1'b1;
      if (!is_seq && wr_vld)        dout <= wr_data;
      else if (pop)                 dout <= mem[rp];
    end
  end

  // R3
  lvl_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));
  // R6
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovr |=> ovr);
  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && empty && !wr_vld) |=> (level == '0) && $stable(dout));
  // R8
  both_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (is_seq && wr_vld && rd_stb && !empty && !full) |=> $stable(level));
endmodule

// File: rtl/spi_rx_irq.sv
module spi_rx_irq
  import spi_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  rx_mode_e      mode,
  input  logic          wr_vld,
  input  logic [LW-1:0] level,
  output logic          irq_fill,
  output logic          irq_end
);
  localparam int unsigned HALF = DEPTH / 2;

  logic [LW-1:0] lvl_q;
  logic          hit_half, hit_full, unit_byte;

  assign hit_half  = (level == LW'(HALF))  && (lvl_q == LW'(HALF-1));
  assign hit_full  = (level == LW'(DEPTH)) && (lvl_q == LW'(DEPTH-1));
  assign unit_byte = (mode == MODE_UNIT) && wr_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q    <= '0;
      irq_fill <= 1'b0;
      irq_end  <= 1'b0;
    end else begin
      lvl_q    <= level;
      irq_fill <= unit_byte | ((mode == MODE_SEQ) & (hit_half | hit_full));
      irq_end  <= unit_byte | ((mode == MODE_SEQ) & hit_full);
    end
  end

  // R9
  fill_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_fill |=> !irq_fill);
  // R9
  end_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_end |=> !irq_end);
  // R5
  end_with_fill_chk: assert property (@(posedge clk) disable iff (rst)
    irq_end |-> irq_fill);
endmodule

// File: rtl/spi_rx_path.sv
module spi_rx_path
  import spi_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_in,
  input  logic              sdata_in,
  input  logic              rd_stb,
  input  logic              seq_mode,
  output logic [BYTE_W-1:0] rd_data,
  output logic [LW-1:0]     fifo_level,
  output logic              irq_fill,
  output logic              irq_end,
  output logic              overrun
);
  rx_mode_e          md;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_q;

  assign md = seq_mode ? MODE_SEQ : MODE_UNIT;

  spi_rx_deser #(.W(BYTE_W)) u_deser (
    .clk(clk), .rst(rst), .sclk(sclk_in), .sdi(sdata_in),
    .byte_vld(byte_vld), .byte_q(byte_q)
  );

  spi_rx_store #(.W(BYTE_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .mode(md), .wr_vld(byte_vld), .wr_data(byte_q),
    .rd_stb(rd_stb), .dout(rd_data), .level(fifo_level), .ovr(overrun)
  );

  spi_rx_irq #(.DEPTH(DEPTH), .LW(LW)) u_irq (
    .clk(clk), .rst(rst), .mode(md), .wr_vld(byte_vld), .level(fifo_level),
    .irq_fill(irq_fill), .irq_end(irq_end)
  );
endmodule

// File: tb/test_spi_rx_path.sv
module test_spi_rx_path;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk_in = 1'b0, sdata_in = 1'b0, rd_stb = 1'b0, seq_mode = 1'b0;
  logic [7:0] rd_data;
  logic [5:0] fifo_level;
  logic       irq_fill, irq_end, overrun;

  int checks = 0, errors = 0;
  int fill_cnt = 0, end_cnt = 0, unpaired = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_rx_path i_spi_rx_path (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .rd_stb(rd_stb), .seq_mode(seq_mode), .rd_data(rd_data),
    .fifo_level(fifo_level), .irq_fill(irq_fill), .irq_end(irq_end),
    .overrun(overrun)
  );

  // stimulus byte in [15:8], expected rd_data in [7:0]
  localparam logic [15:0] VEC [8] = '{
    16'hA5A5, 16'h3C3C, 16'h0000, 16'hFFFF,
    16'h8181, 16'h7E7E, 16'h0101, 16'h8080
  };

  always @(negedge clk) begin
    if (!rst) begin
      if (irq_fill) fill_cnt++;
      if (irq_end)  end_cnt++;
      if (!seq_mode && (irq_fill != irq_end)) unpaired++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sclk_in = 1'b0; sdata_in = b[i];
      @(negedge clk); sclk_in = 1'b1;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b);
    idle(4);
  endtask

  task automatic do_read();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; sclk_in = 1'b0;
    idle(2);
    rst = 1'b0;
    idle(1);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      finish_run();
    end
  end

  initial begin
    int f0, e0;
    do_reset();
    // R10
    chk(rd_data == 0 && fifo_level == 0 && !irq_fill && !irq_end && !overrun,
        "R10 reset state", {rd_data, fifo_level}, 0);

    // R1 R2: unit mode vector walk
    for (int i = 0; i < 8; i++) begin
      send_byte(VEC[i][15:8]);
      chk(rd_data == VEC[i][7:0], "R1 byte assembly", rd_data, VEC[i][7:0]);
      chk(fill_cnt == i + 1 && end_cnt == i + 1, "R2 unit interrupts",
          fill_cnt * 256 + end_cnt, (i + 1) * 257);
      chk(fifo_level == 0, "R2 level stays zero", fifo_level, 0);
    end
    chk(unpaired == 0, "R2 fill and end coincide", unpaired, 0);

    // sequential mode
    seq_mode = 1'b1;
    idle(2);
    f0 = fill_cnt; e0 = end_cnt;
    for (int i = 0; i < 15; i++) send_byte(8'(i * 3 + 1));
    chk(fifo_level == 15, "R3 level 15", fifo_level, 15);
    chk(fill_cnt == f0, "R4 no fill below half", fill_cnt - f0, 0);
    send_byte(8'(15 * 3 + 1));
    chk(fifo_level == 16, "R3 level 16", fifo_level, 16);
    chk(fill_cnt == f0 + 1, "R4 fill at half", fill_cnt - f0, 1);
    chk(end_cnt == e0, "R5 no end at half", end_cnt - e0, 0);
    for (int i = 16; i < 32; i++) send_byte(8'(i * 3 + 1));
    chk(fifo_level == 32, "R3 level 32", fifo_level, 32);
    chk(fill_cnt == f0 + 2, "R4 fill at full", fill_cnt - f0, 2);
    chk(end_cnt == e0 + 1, "R5 end at full", end_cnt - e0, 1);
    chk(!overrun, "R6 no overrun yet", overrun, 0);

    send_byte(8'hEE);
    chk(overrun, "R6 overrun set", overrun, 1);
    chk(fifo_level == 32, "R6 level held", fifo_level, 32);

    for (int i = 0; i < 16; i++) begin
      do_read();
      chk(rd_data == 8'(i * 3 + 1), "R3 read order", rd_data, 8'(i * 3 + 1));
    end
    chk(fifo_level == 16, "R3 level after reads", fifo_level, 16);
    chk(fill_cnt == f0 + 2, "R4 no fill on fall to half", fill_cnt - f0, 2);

    // R8: push and pop on the same edge
    send_bits(8'h5A);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    idle(3);
    chk(fifo_level == 16, "R8 level unchanged", fifo_level, 16);
    chk(rd_data == 8'(16 * 3 + 1), "R8 popped byte", rd_data, 8'(16 * 3 + 1));

    for (int i = 17; i < 32; i++) begin
      do_read();
      chk(rd_data == 8'(i * 3 + 1), "R3 drain order", rd_data, 8'(i * 3 + 1));
    end
    do_read();
    chk(rd_data == 8'h5A, "R8 stored byte last", rd_data, 8'h5A);
    chk(fifo_level == 0, "R3 drained", fifo_level, 0);

    // R7: empty read
    do_read();
    idle(1);
    chk(rd_data == 8'h5A, "R7 data kept", rd_data, 8'h5A);
    chk(fifo_level == 0, "R7 level kept", fifo_level, 0);
    chk(overrun, "R6 overrun sticky", overrun, 1);

    do_reset();
    chk(rd_data == 0 && fifo_level == 0 && !overrun && !irq_fill && !irq_end,
        "R10 reset clears", {overrun, rd_data, fifo_level}, 0);

    done = 1'b1;
    finish_run();
  end
endmodule